// File: doc/BRIEF.md
# Downward-Growing Stack Pointer with Cached Top Entry

This block keeps the pointer of a stack that grows from the top of a 16-bit data address space toward lower addresses. It takes one-cycle push and pop flags from the surrounding bus logic, plus a synchronous clear, and drives a single-port data memory: a write for each push and a refill read shortly after each pop. Only the low byte of the pointer moves. The high byte is fixed at all ones, so the stack has 256 entries in the highest page of memory.

Beside the pointer, the block holds a register with a copy of the top entry. A consumer that reads the stack gets that copy at once, with no memory access. A push loads the register with the byte being written. A pop raises a flag that is delayed by one cycle. In the delayed cycle the block reads the entry that is now on top and, after the one-cycle memory latency, loads it into the register. A push that arrives while a refill is outstanding takes the memory port and makes the refill void, because the pushed byte is then the correct top.

Top module: `dstk_ctrl`

## Requirements
- R1: After asynchronous reset, `sp` is 0xFFFF, `top_data` is 0x00 and neither `mem_we` nor `mem_re` is asserted.
- R2: In a cycle with `push` high and `clr` low, `mem_we` is 1, `mem_addr` equals `sp` and `mem_wdata` equals `push_data`. At the next edge the low byte of `sp` decrements by one.
- R3: A cycle with only `pop` high writes nothing to memory, and at the next edge the low byte of `sp` increments by one.
- R4: Bits 15:8 of `sp` are always 0xFF. The low byte wraps modulo 256: a push at 0xFF00 gives 0xFFFF, and a pop at 0xFFFF gives 0xFF00.
- R5: From the cycle after a push, `top_data` equals the pushed byte, and the push issues no memory read.
- R6: In the cycle after a pop, if that cycle has no push and no clear, `mem_re` is 1 and `mem_addr` is `sp` with its low byte plus one (mod 256), which is the new top entry. From the third cycle after the pop, `top_data` equals the byte stored at that address.
- R7: When `push` and `pop` are both high, only the push takes effect: the write happens, `sp` decrements, and the next cycle has no refill read.
- R8: A push in either cycle of an outstanding refill (the read cycle or the data-return cycle) voids that refill. `mem_re` is never high in the same cycle as `mem_we`, and `top_data` keeps the pushed byte.
- R9: `clr` overrides push and pop. In a `clr` cycle there is no write and no read. At the next edge `sp` returns to 0xFFFF and `top_data` to 0x00, and any outstanding refill is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous stack clear request |
| push | input | 1 | One-cycle push flag |
| pop | input | 1 | One-cycle pop flag |
| push_data | input | 8 | Byte to push |
| sp | output | 16 | Current stack pointer |
| top_data | output | 8 | Cached top-of-stack byte |
| mem_addr | output | 16 | Data memory address |
| mem_we | output | 1 | Data memory write enable |
| mem_wdata | output | 8 | Data memory write data |
| mem_re | output | 1 | Data memory read enable |
| mem_rdata | input | 8 | Data memory read data, one cycle after `mem_re` |

## Verification
A wrong pointer shows up in the same cycle as the next push, as a wrong `mem_addr`. Because the pointer is compared after every single operation, an off-by-one is found at the first step where it occurs. A refill that is lost, read from the wrong address, or lands on top of a newer push leaves a wrong `top_data` two edges after the read cycle. The bench checks `top_data` at exactly that point after every pop of a full 256-entry fill and drain. A broken priority among clear, push and pop shows up as a write strobe, or a missing write strobe, in the cycle of the conflicting request.

// File: rtl/dstk_pkg.sv
package dstk_pkg;

   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_PUSH = 2'd1,
      OP_POP  = 2'd2,
      OP_CLR  = 2'd3
   } dstk_op_e;

   // clear beats push, push beats pop
   function automatic dstk_op_e pick_op(input logic clr, input logic push, input logic pop);
      dstk_op_e r;
      if (clr)       r = OP_CLR;
      else if (push) r = OP_PUSH;
      else if (pop)  r = OP_POP;
      else           r = OP_IDLE;
      return r;
   endfunction

   // ops that leave the memory port free for a refill read
   function automatic logic port_free(input dstk_op_e op);
      return (op == OP_IDLE) || (op == OP_POP);
   endfunction

endpackage

// File: rtl/dstk_ptr.sv
module dstk_ptr
   import dstk_pkg::*;
#(
   parameter int AW = 16,
   parameter int PW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  dstk_op_e      op,
   output logic [AW-1:0] sp,
   output logic [AW-1:0] sp_above
);
   localparam int HW = AW - PW;
   localparam logic [PW-1:0] ONE = PW'(1);

   logic [PW-1:0] lo_q;
   logic [PW-1:0] lo_nx;
   logic [PW-1:0] lo_up;

   assign lo_up = lo_q + ONE;

   always_comb begin
      unique case (op)
         OP_CLR:  lo_nx = '1;
         OP_PUSH: lo_nx = lo_q - ONE;
         OP_POP:  lo_nx = lo_up;
         default: lo_nx = lo_q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lo_q <= '1;
      else        lo_q <= lo_nx;
   end

   generate
      if (HW > 0) begin : g_paged
         assign sp       = {{HW{1'b1}}, lo_q};
         assign sp_above = {{HW{1'b1}}, lo_up};
      end else begin : g_flat
         assign sp       = lo_q;
         assign sp_above = lo_up;
      end
   endgenerate

endmodule

// File: rtl/dstk_refill.sv
module dstk_refill
   import dstk_pkg::*;
#(
   parameter int RD_LAT = 1
)(
   input  logic     clk,
   input  logic     rst_n,
   input  dstk_op_e op,
   output logic     rd_req,
   output logic     load
);
   logic pop_d_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pop_d_q <= 1'b0;
      else        pop_d_q <= (op == OP_POP);
   end

   // delayed pop issues the read unless a push or clear owns the cycle
   assign rd_req = pop_d_q && port_free(op);

   generate
      if (RD_LAT == 0) begin : g_lat0
         assign load = rd_req;
      end else begin : g_lat1
         logic pend_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pend_q <= 1'b0;
            else        pend_q <= rd_req;
         end
         assign load = pend_q && port_free(op);
      end
   endgenerate

endmodule

// File: rtl/dstk_cache.sv
module dstk_cache
   import dstk_pkg::*;
#(
   parameter int DW = 8
)(
   input  logic          clk,
   input  logic          rst_n,
   input  dstk_op_e      op,
   input  logic          load,
   input  logic [DW-1:0] push_data,
   input  logic [DW-1:0] mem_rdata,
   output logic [DW-1:0] top
);
   logic [DW-1:0] top_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              top_q <= '0;
      else if (op == OP_CLR)   top_q <= '0;
      else if (op == OP_PUSH)  top_q <= push_data;
      else if (load)           top_q <= mem_rdata;
   end

   assign top = top_q;

endmodule

// File: rtl/dstk_ctrl.sv
module dstk_ctrl
   import dstk_pkg::*;
#(
   parameter int AW     = 16,
   parameter int PW     = 8,
   parameter int DW     = 8,
   parameter int RD_LAT = 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] push_data,
   output logic [AW-1:0] sp,
   output logic [DW-1:0] top_data,
   output logic [AW-1:0] mem_addr,
   output logic          mem_we,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata
);
   generate
      if (PW < 1 || PW > AW) begin : g_bad_pw
         $error("dstk_ctrl: PW must lie in 1..AW");
      end
      if (DW < 1) begin : g_bad_dw
         $error("dstk_ctrl: DW must be at least 1");
      end
      if (RD_LAT != 0 && RD_LAT != 1) begin : g_bad_lat
         $error("dstk_ctrl: RD_LAT must be 0 or 1");
      end
   endgenerate

   dstk_op_e      op;
   logic [AW-1:0] sp_above;
   logic          rd_req;
   logic          load;

   assign op = pick_op(clr, push, pop);

   dstk_ptr #(.AW(AW), .PW(PW)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .sp       (sp),
      .sp_above (sp_above)
   );

   dstk_refill #(.RD_LAT(RD_LAT)) u_refill (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .rd_req (rd_req),
      .load   (load)
   );

   dstk_cache #(.DW(DW)) u_cache (
      .clk       (clk),
      .rst_n     (rst_n),
      .op        (op),
      .load      (load),
      .push_data (push_data),
      .mem_rdata (mem_rdata),
      .top       (top_data)
   );

   assign mem_we    = (op == OP_PUSH);
   assign mem_re    = rd_req;
   assign mem_wdata = push_data;
   assign mem_addr  = (op == OP_PUSH) ? sp : sp_above;

endmodule

// File: rtl/dstk_chk.sv
module dstk_chk #(
   parameter int AW = 16,
   parameter int PW = 8,
   parameter int DW = 8
)(
   input logic          clk,
   input logic          rst_n,
   input logic          clr,
   input logic          push,
   input logic          pop,
   input logic [DW-1:0] push_data,
   input logic [AW-1:0] sp,
   input logic [DW-1:0] top_data,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re
);
   localparam logic [AW-1:0] LOMASK = {AW{1'b1}} >> (AW - PW);
   localparam logic [AW-1:0] ONE    = AW'(1);

   function automatic logic [AW-1:0] lo_add(input logic [AW-1:0] a, input logic [AW-1:0] d);
      return (a & ~LOMASK) | ((a + d) & LOMASK);
   endfunction

   // R1 and R9: a clear request returns the pointer to the top address
   p_clear_top_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (sp == {AW{1'b1}}) && (top_data == '0));

   // R9: clear blocks the memory port
   p_clear_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clr |-> !mem_we && !mem_re);

   // R2: push writes at the pointer, then decrements the low part
   p_push_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |-> mem_we && (mem_addr == sp));

   p_push_dec_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |=> sp == lo_add($past(sp), {AW{1'b1}}));

   // R3: pop alone increments the low part without writing
   p_pop_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && !clr) |-> !mem_we ##1 (sp == lo_add($past(sp), ONE)));

   // R4: upper bits stay all ones
   p_high_const_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sp | LOMASK) == {AW{1'b1}});

   // R5: pushed byte is the cached top on the next cycle
   p_push_cache_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (push && !clr) |=> top_data == $past(push_data));

   // R6: delayed pop reads the new top entry
   p_refill_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(pop && !push && !clr) && !push && !clr)
         |-> mem_re && (mem_addr == lo_add(sp, ONE)));

   // R7 and R8: never read and write together
   p_port_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   // R7: a push that wins over a pop leaves no refill behind
   p_push_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !clr) |=> !mem_re || push);

endmodule

bind dstk_ctrl dstk_chk #(.AW(AW), .PW(PW), .DW(DW)) u_dstk_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .clr       (clr),
   .push      (push),
   .pop       (pop),
   .push_data (push_data),
   .sp        (sp),
   .top_data  (top_data),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re)
);

// File: tb/dstk_ctrl_bench.sv
`timescale 1ns/1ps
module dstk_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        clr = 1'b0;
   logic        push = 1'b0;
   logic        pop = 1'b0;
   logic [7:0]  push_data = 8'h00;
   logic [15:0] sp;
   logic [7:0]  top_data;
   logic [15:0] mem_addr;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic        mem_re;
   logic [7:0]  mem_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] ram [0:255];
   logic [7:0] exp_mem [0:255];
   logic [7:0] exp_lo;

   always #5 clk = ~clk;

   dstk_ctrl u_dstk_ctrl (
      .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .pop(pop),
      .push_data(push_data), .sp(sp), .top_data(top_data),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_re(mem_re), .mem_rdata(mem_rdata)
   );

   // memory model: one-cycle read latency
   always_ff @(posedge clk) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      if (mem_re) mem_rdata <= ram[mem_addr[7:0]];
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   // all tasks start and end 1 ns after a rising edge
   task automatic do_push(input logic [7:0] v, input bit full_chk);
      push = 1'b1; push_data = v;
      #1;
      if (full_chk) begin
         chk("R2 we", mem_we, 1'b1);
         chk("R2 addr", mem_addr, {8'hFF, exp_lo});
         chk("R2 wdata", mem_wdata, v);
         chk("R5 no read", mem_re, 1'b0);
      end
      tick();
      push = 1'b0;
      exp_mem[exp_lo] = v;
      exp_lo = exp_lo - 8'd1;
      if (full_chk) begin
         chk("R2 R4 sp", sp, {8'hFF, exp_lo});
         chk("R5 top", top_data, v);
      end
   endtask

   task automatic do_pop_refill();
      pop = 1'b1;
      #1;
      chk("R3 no write", mem_we, 1'b0);
      tick();
      pop = 1'b0;
      exp_lo = exp_lo + 8'd1;
      chk("R3 R4 sp", sp, {8'hFF, exp_lo});
      chk("R6 re", mem_re, 1'b1);
      chk("R6 addr", mem_addr, {8'hFF, exp_lo + 8'd1});
      tick();
      tick();
      chk("R6 top", top_data, exp_mem[exp_lo + 8'd1]);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      exp_lo = 8'hFF;
      for (int i = 0; i < 256; i++) begin ram[i] = 8'h00; exp_mem[i] = 8'h00; end
      repeat (3) @(posedge clk);
      #1;
      chk("R1 sp", sp, 16'hFFFF);
      chk("R1 top", top_data, 8'h00);
      chk("R1 we", mem_we, 1'b0);
      chk("R1 re", mem_re, 1'b0);
      rst_n = 1'b1;
      tick();

      // full fill: pointer wraps 0x00 -> 0xFF on the last push (R4)
      for (int i = 0; i < 256; i++) do_push(8'((i * 7 + 3) & 8'hFF), 1'b1);
      chk("R4 wrap after fill", sp, 16'hFFFF);

      // full drain with refill check after every pop
      for (int i = 0; i < 256; i++) do_pop_refill();
      chk("R4 wrap after drain", sp, 16'hFFFF);

      // back-to-back pops
      clr = 1'b1; tick(); clr = 1'b0; exp_lo = 8'hFF;
      do_push(8'hA1, 1'b0); do_push(8'hB2, 1'b0); do_push(8'hC3, 1'b0);
      pop = 1'b1; tick(); tick(); pop = 1'b0;
      exp_lo = exp_lo + 8'd2;
      chk("R6 b2b sp", sp, {8'hFF, exp_lo});
      tick(); tick();
      chk("R6 b2b top", top_data, 8'hA1);

      // push and pop together
      push = 1'b1; pop = 1'b1; push_data = 8'h5A;
      #1;
      chk("R7 we", mem_we, 1'b1);
      tick();
      push = 1'b0; pop = 1'b0;
      exp_mem[exp_lo] = 8'h5A; exp_lo = exp_lo - 8'd1;
      chk("R7 sp", sp, {8'hFF, exp_lo});
      chk("R7 no refill", mem_re, 1'b0);
      tick(); tick();
      chk("R7 top", top_data, 8'h5A);

      // push in the refill read cycle
      pop = 1'b1; tick(); pop = 1'b0; exp_lo = exp_lo + 8'd1;
      push = 1'b1; push_data = 8'h77;
      #1;
      chk("R8 re blocked", mem_re, 1'b0);
      chk("R8 we", mem_we, 1'b1);
      tick(); push = 1'b0; exp_mem[exp_lo] = 8'h77; exp_lo = exp_lo - 8'd1;
      tick(); tick();
      chk("R8 top read cycle", top_data, 8'h77);

      // push in the data-return cycle
      pop = 1'b1; tick(); pop = 1'b0; exp_lo = exp_lo + 8'd1;
      tick();
      do_push(8'h99, 1'b0);
      tick(); tick();
      chk("R8 top return cycle", top_data, 8'h99);
      chk("R8 sp", sp, {8'hFF, exp_lo});

      // clear with push
      clr = 1'b1; push = 1'b1; push_data = 8'hEE;
      #1;
      chk("R9 no write", mem_we, 1'b0);
      tick(); clr = 1'b0; push = 1'b0; exp_lo = 8'hFF;
      chk("R9 sp", sp, 16'hFFFF);
      chk("R9 top", top_data, 8'h00);

      // clear during an outstanding refill
      do_push(8'h3C, 1'b0); do_push(8'h4D, 1'b0);
      pop = 1'b1; tick(); pop = 1'b0;
      clr = 1'b1;
      #1;
      chk("R9 read dropped", mem_re, 1'b0);
      tick(); clr = 1'b0;
      tick(); tick();
      chk("R9 refill dropped", top_data, 8'h00);
      chk("R9 sp after drop", sp, 16'hFFFF);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule